// File: doc/BRIEF.md
# Four-Channel Shared-Period PWM Generator

This block drives four pulse-width-modulated pins from a single free-running 8-bit up-counter. The counter advances once for each clock on which the count-enable input is high. When it reaches its top value it restarts from a shared, programmable reload value instead of wrapping to zero. That restart is the common leading edge of all four channels, and the period is therefore 256 minus the reload value.

Each channel compares the counter against its own compare register, and that comparison places the channel's trailing edge. The compare register takes its value from a software-writable duty register, but only at the counter restart, so the waveform never glitches in mid-period. A control register holds, per channel, an enable that gates the pin and drives the matching enable flag, and a polarity bit that inverts the waveform as soon as it is written.

Software reaches the control, reload and duty registers through a small synchronous write / combinational read register bus.

Top module: `pwm_quad`

## Requirements
- R1: After reset, every register reads 00h, all four pins are low and all four enable flags are low.
- R2: Register map. Address 0 is control: bits 7:4 are the output enables for channel 3 down to channel 0, and bits 3:0 are the polarity bits for channel 3 down to channel 0. Address 1 is the reload value. Addresses 4 to 7 are the duty registers of channels 0 to 3. Every register reads back what was written. Addresses 2 and 3 read 00h, and writes to them change nothing.
- R3: The counter advances by one only on clocks with `cnt_en` high, and holds otherwise. An enabled clock at FFh loads the reload value, so a channel repeats every 256 minus reload enabled clocks.
- R4: With polarity 0, a channel's level is high while the counter is less than or equal to its compare value, and low while the counter is greater.
- R5: With polarity 1, the channel's level is the inverse of the R4 level.
- R6: A write to a polarity bit changes that channel's pin in the cycle after the write, with the counter frozen and no period boundary passed.
- R7: A compare register takes its duty register's value only on the enabled clock at which the counter is at FFh. A duty write therefore has no effect on the pin before the next restart.
- R8: With its output enable at 0, a channel's pin and enable flag are low, while its counter comparison and compare loading keep running. Setting the enable shows the current level at once.
- R9: A duty value below the reload value keeps a channel at its inactive level for the whole period. A duty value of FFh keeps it at its active level for the whole period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cnt_en | input | 1 | Counter clock enable: one tick per high cycle |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one register write per high cycle |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pwm_out | output | 4 | PWM pin levels, bit n is channel n |
| pwm_oe | output | 4 | Pin enable flags, bit n is channel n |

## Verification
The comparison is tried against a table of reload, duty and polarity settings, and high cycles are counted over one full period on every channel. Duty values inside the period, at its first count, below the reload value and at FFh separate an off-by-one in the less-or-equal test, a missing reload and a wrapping counter. Inverted patterns separate polarity from duty. Directed runs freeze the counter to split immediate effects (polarity, enable) from effects that wait for the restart (duty), and they measure the pulse spacing to pin the period length.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;
  localparam int DATA_W     = 8;
  localparam int NUM_CH     = 4;
  localparam int ADDR_CTRL  = 0;
  localparam int ADDR_RELD  = 1;
endpackage

// File: rtl/pwm_quad_regs.sv
module pwm_quad_regs
  import pwm_quad_pkg::*;
#(
  parameter int DW   = DATA_W,
  parameter int NCH  = NUM_CH,
  parameter int AW   = $clog2(NCH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  input  logic              we,
  output logic [DW-1:0]     rdata,
  output logic [NCH-1:0]    oe_q,
  output logic [NCH-1:0]    pol_q,
  output logic [DW-1:0]     reload_q,
  output logic [NCH*DW-1:0] duty_flat
);
  localparam int SELW = $clog2(NCH);

  logic [DW-1:0]  duty_q [NCH];
  logic [DW-1:0]  duty_d [NCH];
  logic [NCH-1:0] oe_d, pol_d;
  logic [DW-1:0]  reload_d;
  logic [SELW-1:0] sel;

  assign sel = addr[SELW-1:0];

  // next-state
  always_comb begin
    oe_d     = oe_q;
    pol_d    = pol_q;
    reload_d = reload_q;
    for (int i = 0; i < NCH; i++) duty_d[i] = duty_q[i];
    if (we) begin
      if (addr[AW-1])                    duty_d[sel] = wdata;
      else if (addr == AW'(ADDR_CTRL))   {oe_d, pol_d} = wdata[2*NCH-1:0];
      else if (addr == AW'(ADDR_RELD))   reload_d = wdata;
    end
  end

  // state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q     <= '0;
      pol_q    <= '0;
      reload_q <= '0;
      for (int i = 0; i < NCH; i++) duty_q[i] <= '0;
    end else begin
      oe_q     <= oe_d;
      pol_q    <= pol_d;
      reload_q <= reload_d;
      for (int i = 0; i < NCH; i++) duty_q[i] <= duty_d[i];
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    if (addr[AW-1])                    rdata = duty_q[sel];
    else if (addr == AW'(ADDR_CTRL))   rdata = DW'({oe_q, pol_q});
    else if (addr == AW'(ADDR_RELD))   rdata = reload_q;
  end

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_flat
      assign duty_flat[g*DW +: DW] = duty_q[g];
    end
  endgenerate
endmodule

// File: rtl/pwm_quad_timebase.sv
module pwm_quad_timebase #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [DW-1:0] reload,
  output logic [DW-1:0] cnt_q,
  output logic          wrap
);
  localparam logic [DW-1:0] TOP = {DW{1'b1}};

  logic [DW-1:0] cnt_d;

  assign wrap = tick && (cnt_q == TOP);

  always_comb begin
    cnt_d = cnt_q;
    if (tick) cnt_d = (cnt_q == TOP) ? reload : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pwm_quad_chan.sv
module pwm_quad_chan #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] duty,
  input  logic [DW-1:0] cnt,
  input  logic          oe,
  input  logic          pol,
  output logic [DW-1:0] cmp_q,
  output logic          pin
);
  logic [DW-1:0] cmp_d;
  logic          level;

  always_comb begin
    cmp_d = cmp_q;
    if (load) cmp_d = duty;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp_q <= '0;
    else        cmp_q <= cmp_d;
  end

  assign level = (cnt <= cmp_q) ^ pol;
  assign pin   = oe & level;
endmodule

// File: rtl/pwm_quad.sv
module pwm_quad
  import pwm_quad_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int NCH = NUM_CH,
  parameter int AW  = $clog2(NCH) + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cnt_en,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  input  logic           bus_we,
  output logic [DW-1:0]  bus_rdata,
  output logic [NCH-1:0] pwm_out,
  output logic [NCH-1:0] pwm_oe
);
  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic [NCH-1:0]    oe_q, pol_q;
  logic [DW-1:0]     reload_q, cnt_q;
  logic [NCH*DW-1:0] duty_flat, cmp_flat;
  logic              wrap;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  pwm_quad_regs #(.DW(DW), .NCH(NCH), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .addr(bus_addr), .wdata(bus_wdata),
    .we(bus_we), .rdata(bus_rdata), .oe_q(oe_q), .pol_q(pol_q),
    .reload_q(reload_q), .duty_flat(duty_flat)
  );

  pwm_quad_timebase #(.DW(DW)) u_tb (
    .clk(clk), .rst_n(rst_sync_n), .tick(cnt_en), .reload(reload_q),
    .cnt_q(cnt_q), .wrap(wrap)
  );

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_ch
      pwm_quad_chan #(.DW(DW)) u_ch (
        .clk(clk), .rst_n(rst_sync_n), .load(wrap),
        .duty(duty_flat[g*DW +: DW]), .cnt(cnt_q), .oe(oe_q[g]),
        .pol(pol_q[g]), .cmp_q(cmp_flat[g*DW +: DW]), .pin(pwm_out[g])
      );
    end
  endgenerate

  assign pwm_oe = oe_q;
endmodule

// File: rtl/pwm_quad_checker.sv
module pwm_quad_checker #(
  parameter int DW  = 8,
  parameter int NCH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cnt_en,
  input logic [DW-1:0]     cnt,
  input logic [DW-1:0]     reload,
  input logic [NCH-1:0]    oe,
  input logic [NCH-1:0]    pol,
  input logic [NCH*DW-1:0] duty_flat,
  input logic [NCH*DW-1:0] cmp_flat,
  input logic [NCH-1:0]    pwm_out,
  input logic [NCH-1:0]    pwm_oe
);
  localparam logic [DW-1:0] TOP = {DW{1'b1}};

  logic at_top;
  assign at_top = cnt_en && (cnt == TOP);

  p_cnt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> $stable(cnt));

  p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && cnt != TOP) |=> (cnt == $past(cnt) + 1'b1));

  p_cnt_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    at_top |=> (cnt == $past(reload)));

  p_cmp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !at_top |=> $stable(cmp_flat));

  p_cmp_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    at_top |=> (cmp_flat == $past(duty_flat)));

  p_pin_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_out & ~pwm_oe) == '0);

  p_pol_now_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(cnt) && $stable(cmp_flat) && $stable(oe)) |->
      (pwm_out == ($past(pwm_out) ^ ((pol ^ $past(pol)) & oe))));
endmodule

bind pwm_quad pwm_quad_checker #(.DW(DW), .NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .cnt_en(cnt_en), .cnt(cnt_q),
  .reload(reload_q), .oe(oe_q), .pol(pol_q), .duty_flat(duty_flat),
  .cmp_flat(cmp_flat), .pwm_out(pwm_out), .pwm_oe(pwm_oe)
);

// File: tb/pwm_quad_test.sv
module pwm_quad_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt_en = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_rdata;
  logic [3:0] pwm_out, pwm_oe;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  pwm_quad uut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(bus_rdata),
    .pwm_out(pwm_out), .pwm_oe(pwm_oe)
  );

  // {reload, duty (all channels), control, expected high cycles per period}
  localparam logic [39:0] VECS [9] = '{
    {8'h00, 8'h7F, 8'hF0, 16'd128},  // R4 mid duty, full period
    {8'h00, 8'hFF, 8'hF0, 16'd256},  // R9 always active
    {8'h80, 8'h7F, 8'hF0, 16'd0},    // R9 duty below reload
    {8'h80, 8'h80, 8'hF0, 16'd1},    // R4 duty at first count
    {8'h80, 8'hBF, 8'hF0, 16'd64},   // R3 R4 shortened period
    {8'h80, 8'h9F, 8'hFF, 16'd96},   // R5 inverted
    {8'hF0, 8'hF3, 8'hFF, 16'd12},   // R5 short period inverted
    {8'hC0, 8'hFF, 8'h0F, 16'd0},    // R8 outputs disabled
    {8'h00, 8'h00, 8'hF0, 16'd1}     // R4 duty zero
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [2:0] a, logic [7:0] exp);
    bus_addr = a;
    #1;
    chk(req, 32'(bus_rdata), 32'(exp));
  endtask

  task automatic configure(logic [7:0] r, logic [7:0] d, logic [7:0] c);
    wr(3'd1, r);
    for (int i = 0; i < 4; i++) wr(3'(4 + i), d);
    wr(3'd0, c);
    repeat (260) @(negedge clk);
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int hi [4];
    int gap;
    logic [3:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) rd_chk("R1 reset read", 3'(a), 8'h00);
    chk("R1 pins low", 32'(pwm_out), 0);
    chk("R1 flags low", 32'(pwm_oe), 0);

    // R2 register map
    wr(3'd0, 8'hA5); wr(3'd1, 8'h3C);
    wr(3'd4, 8'h11); wr(3'd5, 8'h22); wr(3'd6, 8'h33); wr(3'd7, 8'h44);
    wr(3'd2, 8'hFF); wr(3'd3, 8'hEE);
    rd_chk("R2 ctrl", 3'd0, 8'hA5);
    rd_chk("R2 reload", 3'd1, 8'h3C);
    rd_chk("R2 duty0", 3'd4, 8'h11);
    rd_chk("R2 duty1", 3'd5, 8'h22);
    rd_chk("R2 duty2", 3'd6, 8'h33);
    rd_chk("R2 duty3", 3'd7, 8'h44);
    rd_chk("R2 hole2", 3'd2, 8'h00);
    rd_chk("R2 hole3", 3'd3, 8'h00);
    chk("R2 enable flags follow ctrl[7:4]", 32'(pwm_oe), 32'hA);

    cnt_en = 1'b1;
    // vector table: R3 R4 R5 R8 R9
    for (int k = 0; k < 9; k++) begin
      logic [7:0] r, d, c;
      int p;
      {r, d, c} = VECS[k][39:16];
      configure(r, d, c);
      p = 256 - int'(r);
      for (int i = 0; i < 4; i++) hi[i] = 0;
      for (int t = 0; t < p; t++) begin
        for (int i = 0; i < 4; i++) if (pwm_out[i]) hi[i]++;
        @(negedge clk);
      end
      for (int i = 0; i < 4; i++)
        chk($sformatf("R4 R5 R9 vector %0d ch%0d high count", k, i),
            32'(hi[i]), 32'(VECS[k][15:0]));
    end

    // R3 period spacing: reload F0, duty F0 -> one-cycle pulse every 16 ticks
    configure(8'hF0, 8'hF0, 8'hF0);
    while (pwm_out[0] !== 1'b1) @(negedge clk);
    @(negedge clk);
    gap = 1;
    while (pwm_out[0] !== 1'b1 && gap < 400) begin @(negedge clk); gap++; end
    chk("R3 pulse spacing", 32'(gap), 32'd16);
    // R3 hold while disabled
    cnt_en = 1'b0;
    repeat (20) @(negedge clk);
    chk("R3 counter holds without cnt_en", 32'(pwm_out), 32'hF);

    // R6 immediate polarity
    cnt_en = 1'b1;
    configure(8'h00, 8'h7F, 8'hF0);
    cnt_en = 1'b0;
    @(negedge clk);
    v = pwm_out;
    wr(3'd0, 8'hF1);
    chk("R6 polarity flips ch0 only", 32'(pwm_out), 32'(v ^ 4'b0001));

    // R7 duty change waits for restart
    cnt_en = 1'b1;
    configure(8'h00, 8'hFF, 8'hF0);
    cnt_en = 1'b0;
    wr(3'd4, 8'h00);
    repeat (3) @(negedge clk);
    chk("R7 compare not reloaded mid-period", 32'(pwm_out), 32'hF);
    cnt_en = 1'b1;
    repeat (260) @(negedge clk);
    hi[0] = 0;
    for (int t = 0; t < 256; t++) begin
      if (pwm_out[0]) hi[0]++;
      @(negedge clk);
    end
    chk("R7 new duty after restart", 32'(hi[0]), 32'd1);

    // R8 compare keeps loading while disabled
    configure(8'h00, 8'hFF, 8'h00);
    chk("R8 pins low when disabled", 32'(pwm_out), 0);
    chk("R8 flags low when disabled", 32'(pwm_oe), 0);
    cnt_en = 1'b0;
    wr(3'd0, 8'hF0);
    chk("R8 enable shows live level", 32'(pwm_out), 32'hF);
    chk("R8 flags high", 32'(pwm_oe), 32'hF);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule